// File: doc/BRIEF.md
# Per-Bank Open-Row Burst Sequencer

This block holds the open or closed state of each memory bank, together with the row that is open in it. It turns one decoded request at a time into a timed series of commands: a row activate, a precharge (row close), and one data strobe for each burst word. Each data command sets its own behaviour through separate bits. One bit asks for a row activate first, one picks a 4- or 8-word burst, one sets the direction, one asks for the row to be closed after the burst, and one picks one of two data clock pairs. The same request port also carries maintenance requests, which open or close a row and move no data. Writes always cover the whole burst, so there are no byte masks.

A request is taken on a rising clock edge when `req_valid` is high and `busy` is low. Every output is a register, so the first command of a sequence appears in the cycle after the accepting edge. Two cases get extra commands. If an activate targets a bank that holds a different row, the block closes that row first. If the request needs the open row but the bank has none, the block raises an error pulse and sends nothing.

Top module: `bank_burst_seq`

## Requirements
- R1: After a synchronous reset every bank is closed and `busy`, `err`, `act_valid`, `pre_valid` and `dat_valid` are low.
- R2: A request is accepted only on an edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high is dropped and leaves no trace in bank state.
- R3: Command bit 4 set, bank closed: `act_valid` is high for one cycle in the cycle after acceptance, with the requested bank and row. The next cycle is an idle gap, and the data beats for an access follow it.
- R4: Command bit 3 set gives 8 data beats, clear gives 4. The beats run on consecutive cycles with `dat_col` equal to the request column plus the beat index, modulo 2^COL_W, and `dat_last` high only on the final beat.
- R5: On every beat, `dat_write` equals command bit 2 (1 = write) and `dat_clk_sel` equals command bit 0.
- R6: Command bit 4 clear, bank open: the data beats start in the cycle after acceptance, with no activate.
- R7: Command bit 4 clear, bank closed (bit 5 clear): `err` pulses for one cycle after acceptance. No activate, precharge or data is sent, and `busy` stays low.
- R8: Command bit 4 set, bank open with a different row: precharge, gap, activate, gap, then data.
- R9: Command bit 4 set, bank open with the same row: no precharge or activate, and data starts in the cycle after acceptance.
- R10: Command bit 1 set: a precharge of the bank follows the last beat directly. One busy gap cycle follows it, and the bank is closed afterwards.
- R11: Command bit 5 set marks a maintenance request. With bit 4 set it opens the row (closing a different open row first, doing nothing if that row is already open) and sends no data. With bit 4 clear it closes the bank if it is open and otherwise does nothing, with no error.
- R12: `busy` is high in every cycle that carries an activate, precharge, gap or data beat of an accepted request, and low otherwise. At most one of the three command strobes is high in any cycle. Each bank's open row is tracked independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 6 | Command bits (5 maintenance, 4 activate, 3 long burst, 2 write, 1 close after, 0 clock pair) |
| req_bank | input | BANK_W (3) | Target bank |
| req_row | input | ROW_W (12) | Row for activate |
| req_col | input | COL_W (7) | Starting column |
| busy | output | 1 | Sequence in progress, requests not accepted |
| err | output | 1 | One-cycle pulse: access to a closed bank without activate |
| act_valid | output | 1 | Activate strobe |
| act_bank | output | BANK_W | Bank being activated |
| act_row | output | ROW_W | Row being activated |
| pre_valid | output | 1 | Precharge strobe |
| pre_bank | output | BANK_W | Bank being closed |
| dat_valid | output | 1 | Data word strobe |
| dat_write | output | 1 | 1 = write beat, 0 = read beat |
| dat_clk_sel | output | 1 | Data clock pair for this beat |
| dat_bank | output | BANK_W | Bank of this beat |
| dat_col | output | COL_W | Column of this beat |
| dat_last | output | 1 | Final beat of the burst |

## Verification
The bench aims at the row conflict. A design that skipped the precharge, or dropped one of the two gap cycles, would send an activate straight onto an open row or put data right against the activate. It checks column wrap inside a long burst, where a wrong adder width gives a bad `dat_col`. It sends requests while the block is busy, which a design that ignores `busy` would act on and so open a bank unexpectedly. It covers maintenance no-ops and close-after, where a design would either raise a false error or leave a bank marked open. A long run of random traffic, checked cycle by cycle against a behavioural model, mixes all of these across banks.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_PGAP, S_ACT, S_AGAP, S_DATA
  } seq_state_e;

  localparam int CMD_W   = 6;
  localparam int C_MAINT = 5;
  localparam int C_OPEN  = 4;
  localparam int C_LONG  = 3;
  localparam int C_WRITE = 2;
  localparam int C_CLOSE = 1;
  localparam int C_CLK   = 0;

  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = 8;
  localparam int BEAT_W    = $clog2(LONG_LEN);
endpackage

// File: rtl/bbs_bank_table.sv
module bbs_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] rd_bank,
  output logic              rd_open,
  output logic [ROW_W-1:0]  rd_row,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_mem [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else begin
      if (set_en) open_q[set_bank] <= 1'b1;
      if (clr_en) open_q[clr_bank] <= 1'b0;
    end
  end

  // Row storage has no reset so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (set_en) row_mem[set_bank] <= set_row;
  end

  assign rd_open = open_q[rd_bank];
  assign rd_row  = row_mem[rd_bank];

  // A bank is never opened and closed in the same cycle.
  p_set_clr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/bbs_seq_ctrl.sv
module bbs_seq_ctrl
  import bbs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [BANK_W-1:0] tbl_rd_bank,
  input  logic              tbl_open,
  input  logic [ROW_W-1:0]  tbl_row,
  output logic              set_en,
  output logic [BANK_W-1:0] set_bank,
  output logic [ROW_W-1:0]  set_row,
  output logic              clr_en,
  output logic [BANK_W-1:0] clr_bank,
  output logic              busy,
  output logic              err,
  output logic              act_valid,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row,
  output logic              pre_valid,
  output logic [BANK_W-1:0] pre_bank,
  output logic              dat_valid,
  output logic              dat_write,
  output logic              dat_clk_sel,
  output logic [BANK_W-1:0] dat_bank,
  output logic [COL_W-1:0]  dat_col,
  output logic              dat_last
);
  seq_state_e        state_q, state_d;
  logic              act_pend_q, act_pend_d;
  logic              data_q, data_d;
  logic              err_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;

  logic              idle, accept, row_hit, burst_end;
  logic [CMD_W-1:0]  cur_cmd;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [BEAT_W-1:0] last_idx;

  assign idle      = (state_q == S_IDLE);
  assign accept    = idle && req_valid;
  assign cur_cmd   = idle ? req_cmd  : cmd_q;
  assign cur_bank  = idle ? req_bank : bank_q;
  assign cur_row   = idle ? req_row  : row_q;
  assign cur_col   = idle ? req_col  : col_q;
  assign tbl_rd_bank = req_bank;
  assign row_hit   = tbl_open && (tbl_row == req_row);
  assign last_idx  = cmd_q[C_LONG] ? BEAT_W'(LONG_LEN - 1) : BEAT_W'(SHORT_LEN - 1);
  assign burst_end = (beat_q == last_idx);

  always_comb begin
    state_d    = state_q;
    act_pend_d = act_pend_q;
    data_d     = data_q;
    err_d      = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        data_d     = !req_cmd[C_MAINT];
        act_pend_d = 1'b0;
        if (req_cmd[C_OPEN]) begin
          if (row_hit)       state_d = data_d ? S_DATA : S_IDLE;
          else if (tbl_open) begin
            state_d    = S_PRE;
            act_pend_d = 1'b1;
          end else           state_d = S_ACT;
        end else if (data_d) begin
          if (tbl_open) state_d = S_DATA;
          else          err_d   = 1'b1;
        end else if (tbl_open) begin
          state_d = S_PRE;
        end
      end
      S_PRE:  state_d = S_PGAP;
      S_PGAP: state_d = act_pend_q ? S_ACT : S_IDLE;
      S_ACT: begin
        state_d    = S_AGAP;
        act_pend_d = 1'b0;
      end
      S_AGAP: state_d = data_q ? S_DATA : S_IDLE;
      S_DATA: if (burst_end) state_d = cmd_q[C_CLOSE] ? S_PRE : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign beat_d = (state_q == S_DATA) ? beat_q + 1'b1 : '0;

  assign set_en   = (state_d == S_ACT);
  assign set_bank = cur_bank;
  assign set_row  = cur_row;
  assign clr_en   = (state_d == S_PRE);
  assign clr_bank = cur_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      act_pend_q <= 1'b0;
      data_q     <= 1'b0;
      beat_q     <= '0;
      cmd_q      <= '0;
      bank_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      state_q    <= state_d;
      act_pend_q <= act_pend_d;
      data_q     <= data_d;
      beat_q     <= beat_d;
      if (accept) begin
        cmd_q  <= req_cmd;
        bank_q <= req_bank;
        row_q  <= req_row;
        col_q  <= req_col;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      err         <= 1'b0;
      act_valid   <= 1'b0;
      act_bank    <= '0;
      act_row     <= '0;
      pre_valid   <= 1'b0;
      pre_bank    <= '0;
      dat_valid   <= 1'b0;
      dat_write   <= 1'b0;
      dat_clk_sel <= 1'b0;
      dat_bank    <= '0;
      dat_col     <= '0;
      dat_last    <= 1'b0;
    end else begin
      busy        <= (state_d != S_IDLE);
      err         <= err_d;
      act_valid   <= (state_d == S_ACT);
      act_bank    <= cur_bank;
      act_row     <= cur_row;
      pre_valid   <= (state_d == S_PRE);
      pre_bank    <= cur_bank;
      dat_valid   <= (state_d == S_DATA);
      dat_write   <= cur_cmd[C_WRITE];
      dat_clk_sel <= cur_cmd[C_CLK];
      dat_bank    <= cur_bank;
      dat_col     <= cur_col + COL_W'(beat_d);
      dat_last    <= (state_d == S_DATA) &&
                     (beat_d == (cur_cmd[C_LONG] ? BEAT_W'(LONG_LEN - 1) : BEAT_W'(SHORT_LEN - 1)));
    end
  end

  p_act_gap_r3: assert property (@(posedge clk) disable iff (rst)
    act_valid |=> !dat_valid && !act_valid);
  p_pre_gap_r8: assert property (@(posedge clk) disable iff (rst)
    pre_valid |=> !act_valid && !pre_valid);
  p_burst_run_r4: assert property (@(posedge clk) disable iff (rst)
    dat_valid && !dat_last |=> dat_valid);
  p_beat_attr_r5: assert property (@(posedge clk) disable iff (rst)
    dat_valid && !dat_last |=> $stable(dat_write) && $stable(dat_clk_sel));
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy && !act_valid && !pre_valid && !dat_valid);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_valid, pre_valid, dat_valid}));
  p_busy_cover_r12: assert property (@(posedge clk) disable iff (rst)
    (act_valid || pre_valid || dat_valid) |-> busy);
endmodule

// File: rtl/bank_burst_seq.sv
module bank_burst_seq #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [5:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              busy,
  output logic              err,
  output logic              act_valid,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row,
  output logic              pre_valid,
  output logic [BANK_W-1:0] pre_bank,
  output logic              dat_valid,
  output logic              dat_write,
  output logic              dat_clk_sel,
  output logic [BANK_W-1:0] dat_bank,
  output logic [COL_W-1:0]  dat_col,
  output logic              dat_last
);
  logic [BANK_W-1:0] tbl_rd_bank, set_bank, clr_bank;
  logic [ROW_W-1:0]  tbl_row, set_row;
  logic              tbl_open, set_en, clr_en;

  bbs_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_bank(tbl_rd_bank), .rd_open(tbl_open), .rd_row(tbl_row),
    .set_en(set_en), .set_bank(set_bank), .set_row(set_row),
    .clr_en(clr_en), .clr_bank(clr_bank)
  );

  bbs_seq_ctrl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col),
    .tbl_rd_bank(tbl_rd_bank), .tbl_open(tbl_open), .tbl_row(tbl_row),
    .set_en(set_en), .set_bank(set_bank), .set_row(set_row),
    .clr_en(clr_en), .clr_bank(clr_bank),
    .busy(busy), .err(err),
    .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .pre_valid(pre_valid), .pre_bank(pre_bank),
    .dat_valid(dat_valid), .dat_write(dat_write), .dat_clk_sel(dat_clk_sel),
    .dat_bank(dat_bank), .dat_col(dat_col), .dat_last(dat_last)
  );
endmodule

// File: tb/bank_burst_seq_tb.sv
module bank_burst_seq_tb;
  localparam int NB = 8;
  localparam int RW = 12;
  localparam int CW = 7;

  typedef struct packed {
    logic busy, err, act, pre, dat, wr, ck, last;
    logic [2:0]  bank;
    logic [11:0] row;
    logic [6:0]  col;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [5:0]  req_cmd = '0;
  logic [2:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [6:0]  req_col = '0;
  logic busy, err, act_valid, pre_valid, dat_valid, dat_write, dat_clk_sel, dat_last;
  logic [2:0]  act_bank, pre_bank, dat_bank;
  logic [11:0] act_row;
  logic [6:0]  dat_col;

  always #5 clk = ~clk;

  bank_burst_seq #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .busy(busy), .err(err), .act_valid(act_valid), .act_bank(act_bank),
    .act_row(act_row), .pre_valid(pre_valid), .pre_bank(pre_bank),
    .dat_valid(dat_valid), .dat_write(dat_write), .dat_clk_sel(dat_clk_sel),
    .dat_bank(dat_bank), .dat_col(dat_col), .dat_last(dat_last)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  string scen = "R1";
  exp_t q[$];
  exp_t ex = '0;
  bit mopen [NB];
  int mrow [NB];

  task automatic chk(string what, int got, int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL [%s] %s got %0h exp %0h", scen, what, got, want);
    end
  endtask

  function automatic exp_t mk(bit a, bit p, bit d, int b, int r);
    exp_t e = '0;
    e.busy = 1'b1; e.act = a; e.pre = p; e.dat = d;
    e.bank = 3'(b); e.row = 12'(r);
    return e;
  endfunction

  task automatic push_close(int b);
    q.push_back(mk(0, 1, 0, b, 0));
    q.push_back(mk(0, 0, 0, 0, 0));
    mopen[b] = 0;
  endtask

  task automatic push_open(int b, int r);
    if (mopen[b]) push_close(b);
    q.push_back(mk(1, 0, 0, b, r));
    q.push_back(mk(0, 0, 0, 0, 0));
    mopen[b] = 1; mrow[b] = r;
  endtask

  // Reference: expand one accepted request into its cycle-by-cycle outputs.
  task automatic gen(logic [5:0] c, int b, int r, int col);
    bit hit = mopen[b] && (mrow[b] == r);
    int n = c[3] ? 8 : 4;
    if (!c[5]) begin
      if (c[4]) begin
        if (!hit) push_open(b, r);
      end else if (!mopen[b]) begin
        exp_t e = '0;
        e.err = 1'b1;
        q.push_back(e);
        return;
      end
      for (int i = 0; i < n; i++) begin
        exp_t e = mk(0, 0, 1, b, 0);
        e.col = 7'((col + i) % 128);
        e.last = (i == n - 1);
        e.wr = c[2]; e.ck = c[0];
        q.push_back(e);
      end
      if (c[1]) push_close(b);
    end else begin
      if (c[4]) begin
        if (!hit) push_open(b, r);
      end else if (mopen[b]) push_close(b);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < NB; i++) mopen[i] = 0;
      ex = '0;
    end else begin
      if (req_valid && !ex.busy) gen(req_cmd, int'(req_bank), int'(req_row), int'(req_col));
      if (q.size() > 0) ex = q.pop_front();
      else ex = '0;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R12 busy", busy, ex.busy);
      chk("R7 err", err, ex.err);
      chk("R3 act_valid", act_valid, ex.act);
      chk("R8 pre_valid", pre_valid, ex.pre);
      chk("R4 dat_valid", dat_valid, ex.dat);
      if (ex.act) begin
        chk("R3 act_bank", act_bank, ex.bank);
        chk("R3 act_row", act_row, ex.row);
      end
      if (ex.pre) chk("R10 pre_bank", pre_bank, ex.bank);
      if (ex.dat) begin
        chk("R4 dat_col", dat_col, ex.col);
        chk("R4 dat_last", dat_last, ex.last);
        chk("R12 dat_bank", dat_bank, ex.bank);
        chk("R5 dat_write", dat_write, ex.wr);
        chk("R5 dat_clk_sel", dat_clk_sel, ex.ck);
      end
    end
  end

  task automatic issue(logic [5:0] c, int b, int r, int col);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = 3'(b); req_row = 12'(r); req_col = 7'(col);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Command bits: 5 maint, 4 activate, 3 long, 2 write, 1 close after, 0 clock pair
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    scen = "R1"; issue(6'b000000, 0, 0, 0); drain();           // all banks closed after reset
    scen = "R3"; issue(6'b010000, 1, 12'h123, 5); drain();     // activate closed bank, 4-beat read
    scen = "R6"; issue(6'b001101, 1, 0, 7'h7C); drain();       // open row, 8-beat write, wrap, clk1
    scen = "R9"; issue(6'b010001, 1, 12'h123, 9); drain();     // same row: no activate
    scen = "R8"; issue(6'b011110, 1, 12'h456, 0); drain();     // conflict plus close after
    scen = "R10"; issue(6'b000000, 1, 0, 0); drain();          // bank 1 now closed -> err
    scen = "R2";
    issue(6'b011000, 2, 12'h010, 3);
    @(negedge clk); req_valid = 1'b1; req_cmd = 6'b010000; req_bank = 3'd3; req_row = 12'h077;
    @(negedge clk); req_valid = 1'b0;
    drain();
    issue(6'b000000, 3, 0, 0); drain();                        // dropped request left bank 3 closed
    scen = "R11";
    issue(6'b110000, 4, 7, 0); drain();
    issue(6'b110000, 4, 7, 0); drain();
    issue(6'b110000, 4, 8, 0); drain();
    issue(6'b100000, 4, 0, 0); drain();
    issue(6'b100000, 4, 0, 0); drain();
    issue(6'b000000, 4, 0, 0); drain();
    scen = "R12";
    issue(6'b110000, 5, 12'hAAA, 0); issue(6'b110000, 6, 12'h555, 0);
    issue(6'b000100, 5, 0, 1); issue(6'b001000, 6, 0, 2); drain();
    scen = "R4 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      req_valid = ($urandom % 3) != 0;
      req_cmd   = 6'($urandom);
      if (($urandom % 4) != 0) req_cmd[5] = 1'b0;
      req_bank  = 3'($urandom);
      req_row   = 12'($urandom % 3);
      req_col   = 7'($urandom);
    end
    @(negedge clk); req_valid = 1'b0;
    drain();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL [watchdog] run did not finish got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule